// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block makes the SCL waveform for an I2C master from a much faster system clock. A power-of-two prescaler turns the system clock into base ticks. Two phase counters then set how many base ticks SCL stays low and how many it stays released. The byte engine programs one 32-bit timing word, holds `enable_i`, and raises `run_i` for as long as it wants clock phases. The generator drives SCL low for the low phase and then releases it for the high phase. It starts the next period back to back while `run_i` stays high. When `run_i` is low it parks with SCL released.

The byte engine needs to know where SCL changes. One-cycle strobes mark the falling edge and the observed rising edge. Two further strobes mark the middle of the low phase, which is where data is changed, and the middle of the high phase, which is where data is sampled. A target may hold SCL low after the block has released it. The high-phase count then waits until the line reads high, so a stretched clock never loses high time. A new timing word is taken only when a low phase begins, so a phase already running always completes with the settings it started with.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, with `enable_i` high and `run_i` low, `scl_o` is 1 and none of `fall_o`, `rise_o`, `mid_low_o`, `mid_high_o` pulses.
- R2: The timing word fields are decoded as follows:
  - bits [3:0] hold the prescaler exponent `b`;
  - bits [15:12] hold the low count `L`;
  - bits [19:16] hold the high count `H`;
  - bits [31:20] and [11:4] have no effect on the waveform.
- R3: The low phase lasts `(L+1)<<b` system clocks and the high phase lasts `(H+1)<<b` system clocks (counting unstretched cycles only), so an unstretched period is `((L+1)+(H+1))<<b` cycles.
- R4: `fall_o` is high for exactly one cycle: the first cycle in which `scl_o` is 0. `rise_o` is high for exactly one cycle: the first cycle of a high phase in which both `scl_o` and `scl_i` are 1.
- R5: Cycles are indexed from 0 at the first cycle of a phase, counting only cycles in which the phase advances. With `N` the length of the phase in cycles, `mid_low_o` pulses once, at index `N/2` (rounded down) of the low phase, and `mid_high_o` pulses once, at index `N/2` (rounded down) of the high phase.
- R6: While in the high phase with `scl_i` low, the high-phase count holds. `rise_o` and `mid_high_o` stay low, `scl_o` stays 1, and the high phase is extended by the number of stretched cycles.
- R7: The timing word is captured only on the edge that starts a low phase. A change to `timing_word_i` during a period alters neither that period's low phase nor its high phase, and it applies from the next low phase on.
- R8: `run_i` is sampled on the last cycle of each high phase. If it is 1, the next cycle is the first low cycle of a new period. If it is 0, the block goes idle with `scl_o` at 1 and raises no further `fall_o`.
- R9: One cycle after `enable_i` is low, `scl_o` is 1. While `enable_i` stays low, no strobe pulses and `run_i` has no effect.
- R10: From idle, when `enable_i` and `run_i` are both 1 at a clock edge, the very next cycle is the first low cycle, with `fall_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low forces idle with SCL released |
| run_i | input | 1 | Request from the byte engine to keep running clock periods |
| timing_word_i | input | 32 | Timing word: exponent [3:0], low count [15:12], high count [19:16] |
| scl_i | input | 1 | Sampled level of the SCL line |
| scl_o | output | 1 | SCL drive level: 0 pulls the line low, 1 releases it |
| fall_o | output | 1 | One-cycle strobe on the first low cycle |
| rise_o | output | 1 | One-cycle strobe when SCL is first seen high in a high phase |
| mid_low_o | output | 1 | One-cycle strobe at the middle of the low phase |
| mid_high_o | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
With all count fields and the exponent at zero, each phase is one cycle long. The edge strobe and the mid-phase strobe of that phase then fall in the same cycle: `fall_o` with `mid_low_o`, and `rise_o` with `mid_high_o`. The all-zero table vector drives exactly this case. It is judged by requiring both the mid strobe index and the edge strobe at index 0 of their phase, with the next falling edge one cycle later.

A second coincidence is the capture of a new timing word on the same edge that ends a high phase. The bench changes the word in the middle of a period. It then checks that the running period keeps its old lengths and that the following low phase has the new length.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  localparam int DEF_WORD_W   = 32;
  localparam int DEF_BASE_W   = 4;
  localparam int DEF_CNT_W    = 4;
  localparam int DEF_BASE_LSB = 0;
  localparam int DEF_LOW_LSB  = 12;
  localparam int DEF_HIGH_LSB = 16;

endpackage

// File: rtl/scl_cfg_latch.sv
`timescale 1ns/1ps
module scl_cfg_latch #(
  parameter int WORD_W   = 32,
  parameter int BASE_W   = 4,
  parameter int CNT_W    = 4,
  parameter int BASE_LSB = 0,
  parameter int LOW_LSB  = 12,
  parameter int HIGH_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [BASE_W-1:0] base_o,
  output logic [CNT_W-1:0]  low_o,
  output logic [CNT_W-1:0]  high_o
);

  // fields outside the three counts carry other bus timing; not used here
  logic unused_word;
  assign unused_word = ^word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      low_o  <= '0;
      high_o <= '0;
    end else if (load_i) begin
      base_o <= word_i[BASE_LSB +: BASE_W];
      low_o  <= word_i[LOW_LSB  +: CNT_W];
      high_o <= word_i[HIGH_LSB +: CNT_W];
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
`timescale 1ns/1ps
module scl_prescaler #(
  parameter int BASE_W = 4,
  parameter int PRE_W  = (1 << BASE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] base_i,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic              tick_o
);

  logic [PRE_W-1:0] mask;
  logic             wrap;

  assign mask   = ~({PRE_W{1'b1}} << base_i);
  assign wrap   = (pre_o == mask);
  assign tick_o = adv_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_o <= '0;
    else if (clear_i)  pre_o <= '0;
    else if (adv_i)    pre_o <= wrap ? '0 : pre_o + 1'b1;
  end

  // R3: prescaler never counts past its programmed divide
  a_r3_pre_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_o & ~mask) == '0);

endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             run_i,
  input  logic             scl_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] high_i,
  output scl_phase_e       phase_o,
  output logic [CNT_W-1:0] t_o,
  output logic             adv_o,
  output logic             load_o,
  output logic             clear_o,
  output logic             rise_o
);

  scl_phase_e phase_d;
  logic       end_low, end_high;
  logic       seen_high_q;

  assign adv_o    = (phase_o == PH_LOW) | ((phase_o == PH_HIGH) & scl_i);
  assign end_low  = (phase_o == PH_LOW)  & tick_i & (t_o == low_i);
  assign end_high = (phase_o == PH_HIGH) & tick_i & (t_o == high_i);
  assign load_o   = enable_i & run_i & ((phase_o == PH_IDLE) | end_high);
  assign clear_o  = (phase_o == PH_IDLE) | ~enable_i;
  assign rise_o   = (phase_o == PH_HIGH) & scl_i & ~seen_high_q;

  always_comb begin
    phase_d = phase_o;
    if (!enable_i) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_o)
        PH_IDLE: if (load_o)   phase_d = PH_LOW;
        PH_LOW:  if (end_low)  phase_d = PH_HIGH;
        PH_HIGH: if (end_high) phase_d = run_i ? PH_LOW : PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o     <= PH_IDLE;
      t_o         <= '0;
      seen_high_q <= 1'b0;
    end else begin
      phase_o <= phase_d;
      if (phase_d == PH_IDLE || end_low || end_high) t_o <= '0;
      else if (tick_i)                              t_o <= t_o + 1'b1;
      if (phase_o != PH_HIGH || phase_d != PH_HIGH) seen_high_q <= 1'b0;
      else if (scl_i)                                seen_high_q <= 1'b1;
    end
  end

  // R3: tick index stays within the programmed phase count
  a_r3_low_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_LOW) |-> (t_o <= low_i));
  a_r3_high_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_HIGH) |-> (t_o <= high_i));
  // R4: a rise strobe is never repeated in the next cycle
  a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/scl_clock_gen.sv
`timescale 1ns/1ps
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int BASE_W   = DEF_BASE_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int BASE_LSB = DEF_BASE_LSB,
  parameter int LOW_LSB  = DEF_LOW_LSB,
  parameter int HIGH_LSB = DEF_HIGH_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              run_i,
  input  logic [WORD_W-1:0] timing_word_i,
  input  logic              scl_i,
  output logic              scl_o,
  output logic              fall_o,
  output logic              rise_o,
  output logic              mid_low_o,
  output logic              mid_high_o
);

  localparam int PRE_W = (1 << BASE_W) - 1;
  localparam int EL_W  = PRE_W + CNT_W + 1;

  scl_phase_e       phase;
  logic [BASE_W-1:0] base_q;
  logic [CNT_W-1:0]  low_q, high_q, t_cnt;
  logic [PRE_W-1:0]  pre_cnt;
  logic              adv, load, clear, tick;
  logic [EL_W-1:0]   elapsed, low_half, high_half;

  scl_cfg_latch #(
    .WORD_W(WORD_W), .BASE_W(BASE_W), .CNT_W(CNT_W),
    .BASE_LSB(BASE_LSB), .LOW_LSB(LOW_LSB), .HIGH_LSB(HIGH_LSB)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(timing_word_i),
    .base_o(base_q),
    .low_o (low_q),
    .high_o(high_q)
  );

  scl_prescaler #(.BASE_W(BASE_W), .PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .base_i (base_q),
    .clear_i(clear),
    .adv_i  (adv),
    .pre_o  (pre_cnt),
    .tick_o (tick)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .run_i   (run_i),
    .scl_i   (scl_i),
    .tick_i  (tick),
    .low_i   (low_q),
    .high_i  (high_q),
    .phase_o (phase),
    .t_o     (t_cnt),
    .adv_o   (adv),
    .load_o  (load),
    .clear_o (clear),
    .rise_o  (rise_o)
  );

  // cycles elapsed in the current phase; prescaler count is below 1<<base
  assign elapsed   = (EL_W'(t_cnt) << base_q) | EL_W'(pre_cnt);
  assign low_half  = ((EL_W'(low_q)  + EL_W'(1)) << base_q) >> 1;
  assign high_half = ((EL_W'(high_q) + EL_W'(1)) << base_q) >> 1;

  assign scl_o      = (phase != PH_LOW);
  assign fall_o     = (phase == PH_LOW) && (elapsed == '0);
  assign mid_low_o  = (phase == PH_LOW) && (elapsed == low_half);
  assign mid_high_o = (phase == PH_HIGH) && scl_i && (elapsed == high_half);

  // R6: stretched high phase freezes both counters
  a_r6_stretch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_HIGH && !scl_i && enable_i) |=> ($stable(t_cnt) && $stable(pre_cnt)));
  // R7: timing fields change only where a low phase starts
  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_o |-> ($stable(base_q) && $stable(low_q) && $stable(high_q)));
  // R9: disable releases SCL and silences edge strobes
  a_r9_disable_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (scl_o && !fall_o && !rise_o));
  // R4: edge strobes are mutually exclusive
  a_r4_edges_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_o, rise_o}));

endmodule

// File: tb/scl_clock_gen_bench.sv
`timescale 1ns/1ps
module scl_clock_gen_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        run_i = 1'b0;
  logic [31:0] timing_word_i = '0;
  logic        hold_low = 1'b0;
  logic        scl_i, scl_o, fall_o, rise_o, mid_low_o, mid_high_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;
  assign scl_i = scl_o & ~hold_low;

  scl_clock_gen u_scl_clock_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .run_i        (run_i),
    .timing_word_i(timing_word_i),
    .scl_i        (scl_i),
    .scl_o        (scl_o),
    .fall_o       (fall_o),
    .rise_o       (rise_o),
    .mid_low_o    (mid_low_o),
    .mid_high_o   (mid_high_o)
  );

  // word, low len, high len, mid-low index, mid-high index
  localparam logic [31:0] V_WORD [5] = '{32'h0000_0000, 32'h0001_3000, 32'h0004_2001,
                                         32'hFFF0_1FF2, 32'h5A0F_F5A3};
  localparam int V_LO [5] = '{1, 4, 6, 8, 128};
  localparam int V_HI [5] = '{1, 2, 10, 4, 128};
  localparam int V_ML [5] = '{0, 2, 3, 4, 64};
  localparam int V_MH [5] = '{0, 1, 5, 2, 64};

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #0.2;
  endtask

  // starts on a fall cycle, ends on the next fall cycle
  task automatic measure(output int lo, output int hi, output int ml,
                         output int mh, output int rs);
    lo = 0; ml = -1;
    while (scl_o == 1'b0 && lo < 2000) begin
      if (mid_low_o && ml < 0) ml = lo;
      lo++;
      step();
    end
    rs = int'(rise_o);
    hi = 0; mh = -1;
    while (!fall_o && hi < 2000) begin
      if (mid_high_o && mh < 0) mh = hi;
      hi++;
      step();
    end
  endtask

  // counts strobes and driven-low cycles over n cycles
  task automatic idle_watch(int n, output int strobes, output int lows);
    strobes = 0; lows = 0;
    for (int k = 0; k < n; k++) begin
      step();
      if (fall_o || rise_o || mid_low_o || mid_high_o) strobes++;
      if (!scl_o) lows++;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int lo, hi, ml, mh, rs, st, lw;

    // R1: reset and idle
    repeat (3) step();
    rst_ni = 1'b1;
    enable_i = 1'b1;
    check_eq("R1 scl released after reset", int'(scl_o), 1);
    idle_watch(10, st, lw);
    check_eq("R1 no strobes while idle", st, 0);
    check_eq("R1 no low drive while idle", lw, 0);

    // table: R2 field positions, R3 lengths, R4 rise, R5 midpoints, R8 stop
    for (int i = 0; i < 5; i++) begin
      timing_word_i = V_WORD[i];
      run_i = 1'b1;
      step();
      check_eq($sformatf("R10 fall next cycle v%0d", i), int'(fall_o), 1);
      measure(lo, hi, ml, mh, rs);
      check_eq($sformatf("R3 R2 low length v%0d", i), lo, V_LO[i]);
      check_eq($sformatf("R3 R2 high length v%0d", i), hi, V_HI[i]);
      check_eq($sformatf("R5 mid low index v%0d", i), ml, V_ML[i]);
      check_eq($sformatf("R5 mid high index v%0d", i), mh, V_MH[i]);
      check_eq($sformatf("R4 rise on first high v%0d", i), rs, 1);
      check_eq($sformatf("R8 back to back fall v%0d", i), int'(fall_o), 1);
      run_i = 1'b0;
      idle_watch(300, st, lw);
      check_eq($sformatf("R8 single trailing period v%0d", i), lw, V_LO[i] - 1);
      check_eq($sformatf("R8 idle scl released v%0d", i), int'(scl_o), 1);
    end

    // R7: word change mid period applies from next low phase
    timing_word_i = 32'h0001_3000;
    run_i = 1'b1;
    step();
    timing_word_i = 32'h0004_2001;
    measure(lo, hi, ml, mh, rs);
    check_eq("R7 old low kept", lo, 4);
    check_eq("R7 old high kept", hi, 2);
    measure(lo, hi, ml, mh, rs);
    check_eq("R7 new low applied", lo, 6);
    check_eq("R7 new high applied", hi, 10);
    run_i = 1'b0;
    idle_watch(40, st, lw);

    // R6: stretch high phase five cycles
    timing_word_i = 32'h0003_1000;
    run_i = 1'b1;
    hold_low = 1'b1;
    step();
    check_eq("R6 fall at start", int'(fall_o), 1);
    for (int c = 1; c <= 11; c++) begin
      step();
      if (c == 7) begin
        hold_low = 1'b0;
        #0.1;
      end
      check_eq($sformatf("R6 rise cycle %0d", c), int'(rise_o), int'(c == 7));
      check_eq($sformatf("R6 mid high cycle %0d", c), int'(mid_high_o), int'(c == 9));
      check_eq($sformatf("R6 fall cycle %0d", c), int'(fall_o), int'(c == 11));
      if (c >= 2 && c <= 10)
        check_eq($sformatf("R6 scl released cycle %0d", c), int'(scl_o), 1);
    end
    run_i = 1'b0;
    idle_watch(20, st, lw);

    // R9: disable mid low phase, run ignored; R10 restart
    timing_word_i = 32'h0004_2001;
    run_i = 1'b1;
    step();
    step();
    step();
    check_eq("R9 pre-disable low", int'(scl_o), 0);
    enable_i = 1'b0;
    step();
    check_eq("R9 scl released after disable", int'(scl_o), 1);
    idle_watch(20, st, lw);
    check_eq("R9 no strobes while disabled", st, 0);
    check_eq("R9 no low drive while disabled", lw, 0);
    enable_i = 1'b1;
    step();
    check_eq("R10 fall after enable", int'(fall_o), 1);
    check_eq("R10 scl low after enable", int'(scl_o), 0);
    run_i = 1'b0;
    idle_watch(40, st, lw);
    check_eq("R8 idle after restart", int'(scl_o), 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule